// File: doc/BRIEF.md
# Flash Lane Snooper with Bit Striping

This block sits between a byte transmit FIFO and one or two parallel serial-flash byte lanes. It watches each transaction framed by chip select. The first byte sent after chip select goes active is decoded as a flash opcode. The opcode, address bytes and dummy bytes are sent duplicated on every lane. Once the opcode's overhead bytes have gone out, the block switches to striped data mode. In that mode it takes one byte per lane from the FIFO and spreads their bits across the lanes. Returned lane bytes go through the exact inverse mapping before they reach the receive FIFO.

The serial shifter on each lane and the register file are outside the block. A controller pulses `xfer_req` once per transfer step. The block pops the transmit FIFO and drives the lane bytes. It then waits for the lanes to return their bytes and pushes the result, or discards it if the receive FIFO is full. Only one transfer is outstanding at a time. Underflow and overflow are reported as one-cycle event pulses.

Top module: `flash_lane_snooper`

## Requirements
- R1: After reset, and in the cycle after any cycle with `cs_active` low, `phase` is 0 (awaiting opcode). `phase` encodes 0 = awaiting opcode, 1 = skipping overhead bytes, 2 = plain passthrough, 3 = striped data.
- R2: A transfer made while `phase` is 0 takes `tx_head[7:0]` as the opcode. Opcodes 0x02, 0x03, 0x32 and 0xA2 load a skip count of 3. Opcodes 0x0B, 0x3B, 0x6B and 0xBB load 4. Opcode 0xEB loads 6. Each of these moves `phase` to 1.
- R3: Any other opcode moves `phase` to 2. In phase 2 every transfer stays non-striped until `cs_active` drops.
- R4: In phase 1 each transfer lowers the skip count by one. The transfer that brings it to zero moves `phase` to 3, so the transfer after the last overhead byte is the first striped one.
- R5: Outside phase 3 a transfer pops one byte (`tx_pop_cnt` = 1) and sends `tx_head[7:0]` on every lane.
- R6: In phase 3 with LANES = 2 a transfer pops LANES bytes. For global bit g = 8k+j, bit j of lane byte k is bit floor(g/LANES) of head byte (g mod LANES). Head byte i is `tx_head[8i+7:8i]`. With LANES = 1 the data passes unchanged.
- R7: A non-striped transfer pushes only lane 0's returned byte (`rx_push_cnt` = 1, upper bits zero). A striped transfer pushes LANES bytes, each rebuilt by the inverse of the R6 mapping.
- R8: If `rx_full` is high when the lane result arrives, nothing is pushed and `overflow_evt` pulses.
- R9: A request with fewer than the needed bytes in the FIFO (1 outside phase 3, LANES inside it) pops nothing and leaves `phase` unchanged. It pulses `underflow_evt` unless `linear_mode` is high.
- R10: `tx_pop`, `lane_tx_valid` and `underflow_evt` appear in the cycle after the request. `rx_push` or `overflow_evt` appears in the cycle after `lane_rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | High while any chip select is asserted |
| linear_mode | input | 1 | Suppresses underflow events when high |
| xfer_req | input | 1 | Request one transfer step |
| tx_level | input | LVL_W | Bytes held in the transmit FIFO |
| tx_head | input | LANES*8 | Oldest bytes of the transmit FIFO, oldest in bits 7:0 |
| tx_pop | output | 1 | Pop pulse to the transmit FIFO |
| tx_pop_cnt | output | CNT_W | Number of bytes to pop |
| lane_tx_valid | output | 1 | Lane bytes valid pulse |
| lane_tx_data | output | LANES*8 | Byte for each lane, lane 0 in bits 7:0 |
| lane_rx_valid | input | 1 | Lanes return their bytes |
| lane_rx_data | input | LANES*8 | Returned byte for each lane |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Push pulse to the receive FIFO |
| rx_push_cnt | output | CNT_W | Number of bytes pushed |
| rx_push_data | output | LANES*8 | Pushed bytes, first in bits 7:0 |
| underflow_evt | output | 1 | Transmit underflow event |
| overflow_evt | output | 1 | Receive overflow event |
| phase | output | 2 | Current snoop phase (see R1) |
| busy | output | 1 | A transfer is outstanding |

## Verification
On every cycle, the embedded assertions check several rules. A dropped chip select returns the block to opcode wait. Passthrough mode is sticky. Striped mode can only follow the skip phase, and multi-byte pops happen only in striped mode. A push only follows returned lane data and never coincides with an overflow. Linear mode keeps underflow quiet. Other behaviour can only be shown by the directed scenarios: the opcode-to-skip-count table, the exact bit interleave and its inverse, the transfer on which striping starts, and the underflow threshold in striped mode.

// File: rtl/fls_pkg.sv
package fls_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_SKIP   = 2'd1,
    PH_RAW    = 2'd2,
    PH_DATA   = 2'd3
  } phase_t;

  localparam int SKIP_W = 3;

  // Overhead bytes that follow a recognised opcode; 0 means unrecognised.
  function automatic logic [SKIP_W-1:0] skip_for(input logic [7:0] op);
    case (op)
      8'h02, 8'h03, 8'h32, 8'hA2: skip_for = SKIP_W'(3);
      8'h0B, 8'h3B, 8'h6B, 8'hBB: skip_for = SKIP_W'(4);
      8'hEB:                      skip_for = SKIP_W'(6);
      default:                    skip_for = '0;
    endcase
  endfunction

endpackage

// File: rtl/fls_bit_striper.sv
module fls_bit_striper #(
  parameter int LANES   = 2,
  parameter bit INVERSE = 1'b0,
  localparam int BW     = LANES * 8
) (
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  // Global bit g of the striped word comes from byte (g mod LANES),
  // bit floor(g / LANES) of the linear word.
  for (genvar g = 0; g < BW; g++) begin : g_bit
    localparam int LIN = (g % LANES) * 8 + (g / LANES);
    if (!INVERSE) begin : g_fwd
      assign dout[g] = din[LIN];
    end else begin : g_inv
      assign dout[LIN] = din[g];
    end
  end
endmodule

// File: rtl/fls_phase_tracker.sv
module fls_phase_tracker
  import fls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_active,
  input  logic       advance,
  input  logic [7:0] opcode,
  output phase_t     phase
);
  logic [SKIP_W-1:0] left;
  logic [SKIP_W-1:0] load;

  assign load = skip_for(opcode);

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      phase <= PH_OPCODE;
      left  <= '0;
    end else if (advance) begin
      case (phase)
        PH_OPCODE: begin
          if (load != '0) begin
            phase <= PH_SKIP;
            left  <= load;
          end else begin
            phase <= PH_RAW;
          end
        end
        PH_SKIP: begin
          left <= left - 1'b1;
          if (left == SKIP_W'(1)) phase <= PH_DATA;
        end
        default: phase <= phase;
      endcase
    end
  end

  // R1
  idle_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> phase == PH_OPCODE);

  // R3
  raw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RAW && cs_active) |=> phase == PH_RAW);

  // R4
  data_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_SKIP);
endmodule

// File: rtl/flash_lane_snooper.sv
module flash_lane_snooper
  import fls_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int FIFO_DEPTH = 64,
  localparam int BW        = LANES * 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_active,
  input  logic             linear_mode,
  input  logic             xfer_req,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [BW-1:0]    tx_head,
  output logic             tx_pop,
  output logic [CNT_W-1:0] tx_pop_cnt,
  output logic             lane_tx_valid,
  output logic [BW-1:0]    lane_tx_data,
  input  logic             lane_rx_valid,
  input  logic [BW-1:0]    lane_rx_data,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [CNT_W-1:0] rx_push_cnt,
  output logic [BW-1:0]    rx_push_data,
  output logic             underflow_evt,
  output logic             overflow_evt,
  output logic [1:0]       phase,
  output logic             busy
);
  phase_t            ph;
  logic              striping;
  logic              pend_stripe;
  logic [CNT_W-1:0]  need;
  logic              enough;
  logic              start;
  logic              starve;
  logic [BW-1:0]     tx_striped;
  logic [BW-1:0]     rx_linear;

  fls_phase_tracker u_track (
    .clk       (clk),
    .rst       (rst),
    .cs_active (cs_active),
    .advance   (start),
    .opcode    (tx_head[7:0]),
    .phase     (ph)
  );

  fls_bit_striper #(.LANES(LANES), .INVERSE(1'b0)) u_tx_stripe (
    .din  (tx_head),
    .dout (tx_striped)
  );

  fls_bit_striper #(.LANES(LANES), .INVERSE(1'b1)) u_rx_unstripe (
    .din  (lane_rx_data),
    .dout (rx_linear)
  );

  assign striping = (ph == PH_DATA) && (LANES > 1);
  assign need     = striping ? CNT_W'(LANES) : CNT_W'(1);
  assign enough   = tx_level >= LVL_W'(need);
  assign start    = xfer_req && !busy && enough;
  assign starve   = xfer_req && !busy && !enough && !linear_mode;
  assign phase    = ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pop        <= 1'b0;
      tx_pop_cnt    <= '0;
      lane_tx_valid <= 1'b0;
      lane_tx_data  <= '0;
      rx_push       <= 1'b0;
      rx_push_cnt   <= '0;
      rx_push_data  <= '0;
      underflow_evt <= 1'b0;
      overflow_evt  <= 1'b0;
      pend_stripe   <= 1'b0;
      busy          <= 1'b0;
    end else begin
      tx_pop        <= start;
      lane_tx_valid <= start;
      underflow_evt <= starve;
      rx_push       <= 1'b0;
      overflow_evt  <= 1'b0;
      if (start) begin
        tx_pop_cnt   <= need;
        lane_tx_data <= striping ? tx_striped : {LANES{tx_head[7:0]}};
        pend_stripe  <= striping;
        busy         <= 1'b1;
      end
      if (lane_rx_valid && busy) begin
        busy <= 1'b0;
        if (rx_full) begin
          overflow_evt <= 1'b1;
        end else begin
          rx_push      <= 1'b1;
          rx_push_cnt  <= pend_stripe ? CNT_W'(LANES) : CNT_W'(1);
          rx_push_data <= pend_stripe ? rx_linear : BW'(lane_rx_data[7:0]);
        end
      end
    end
  end

  // R8
  ovf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_evt |-> !rx_push);

  // R10
  push_src_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> $past(lane_rx_valid));

  // R9
  linear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    linear_mode |=> !underflow_evt);

  // R6
  pop_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_pop_cnt != CNT_W'(1)) |-> $past(ph) == PH_DATA);
endmodule

// File: tb/sim_flash_lane_snooper.sv
`timescale 1ns/1ps
module sim_flash_lane_snooper;
  localparam int LANES = 2;
  localparam int DEPTH = 64;
  localparam int BW    = LANES * 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(LANES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_active = 1'b0;
  logic linear_mode = 1'b0;
  logic xfer_req = 1'b0;
  logic [LVL_W-1:0] tx_level = '0;
  logic [BW-1:0] tx_head = '0;
  logic tx_pop;
  logic [CNT_W-1:0] tx_pop_cnt;
  logic lane_tx_valid;
  logic [BW-1:0] lane_tx_data;
  logic lane_rx_valid = 1'b0;
  logic [BW-1:0] lane_rx_data = '0;
  logic rx_full = 1'b0;
  logic rx_push;
  logic [CNT_W-1:0] rx_push_cnt;
  logic [BW-1:0] rx_push_data;
  logic underflow_evt, overflow_evt, busy;
  logic [1:0] phase;

  always #2.5 clk = ~clk;

  flash_lane_snooper #(.LANES(LANES), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cs_active(cs_active), .linear_mode(linear_mode),
    .xfer_req(xfer_req), .tx_level(tx_level), .tx_head(tx_head),
    .tx_pop(tx_pop), .tx_pop_cnt(tx_pop_cnt), .lane_tx_valid(lane_tx_valid),
    .lane_tx_data(lane_tx_data), .lane_rx_valid(lane_rx_valid),
    .lane_rx_data(lane_rx_data), .rx_full(rx_full), .rx_push(rx_push),
    .rx_push_cnt(rx_push_cnt), .rx_push_data(rx_push_data),
    .underflow_evt(underflow_evt), .overflow_evt(overflow_evt),
    .phase(phase), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] mem [0:255];
  int rd = 0;
  int wr = 0;

  logic c_txv, c_pop, c_under, c_push, c_ovf;
  logic [CNT_W-1:0] c_popn, c_pushn;
  logic [BW-1:0] c_txd, c_pushd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] spread(input logic [BW-1:0] lin);
    logic [BW-1:0] r = '0;
    for (int g = 0; g < BW; g++) r[g] = lin[(g % LANES) * 8 + g / LANES];
    return r;
  endfunction

  function automatic logic [BW-1:0] gather(input logic [BW-1:0] st);
    logic [BW-1:0] r = '0;
    for (int g = 0; g < BW; g++) r[(g % LANES) * 8 + g / LANES] = st[g];
    return r;
  endfunction

  task automatic refresh();
    int lvl = wr - rd;
    tx_level = LVL_W'(lvl);
    tx_head = {(lvl > 1) ? mem[rd + 1] : 8'h00, (lvl > 0) ? mem[rd] : 8'h00};
  endtask

  task automatic put(input logic [7:0] b);
    mem[wr] = b;
    wr++;
    refresh();
  endtask

  task automatic drain();
    rd = wr;
    refresh();
  endtask

  task automatic xfer(input logic [BW-1:0] rxd);
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    c_txv = lane_tx_valid; c_txd = lane_tx_data; c_pop = tx_pop;
    c_popn = tx_pop_cnt; c_under = underflow_evt;
    c_push = 1'b0; c_ovf = 1'b0; c_pushn = '0; c_pushd = '0;
    if (c_pop) begin
      rd += int'(c_popn);
      refresh();
      lane_rx_valid = 1'b1; lane_rx_data = rxd;
      @(negedge clk); lane_rx_valid = 1'b0;
      c_push = rx_push; c_pushn = rx_push_cnt; c_pushd = rx_push_data; c_ovf = overflow_evt;
    end
  endtask

  task automatic frame_restart();
    @(negedge clk); cs_active = 1'b0;
    @(negedge clk); cs_active = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 reset phase", 32'(phase), 32'd0);
    check("R10 reset pop", 32'(tx_pop), 32'd0);
    check("R10 reset lane valid", 32'(lane_tx_valid), 32'd0);
    check("R7 reset push", 32'(rx_push), 32'd0);
  endtask

  task automatic t_read_cmd();
    logic [BW-1:0] lin;
    frame_restart();
    put(8'h03); put(8'h12); put(8'h34); put(8'h56); put(8'hA5); put(8'h3C);
    xfer(16'h9977);
    check("R5 opcode dup", 32'(c_txd), 32'h0303);
    check("R5 opcode pop 1", 32'(c_popn), 32'd1);
    check("R2 read opcode -> skip", 32'(phase), 32'd1);
    check("R7 lane0 only data", 32'(c_pushd), 32'h0077);
    check("R7 lane0 only count", 32'(c_pushn), 32'd1);
    xfer(16'h0);
    check("R5 addr dup", 32'(c_txd), 32'h1212);
    check("R4 still skipping", 32'(phase), 32'd1);
    xfer(16'h0);
    xfer(16'h0);
    check("R5 last addr dup", 32'(c_txd), 32'h5656);
    check("R4 striped after 3", 32'(phase), 32'd3);
    lin = {8'h3C, 8'hA5};
    xfer(16'hB14E);
    check("R6 striped pop count", 32'(c_popn), 32'd2);
    check("R6 striped lanes", 32'(c_txd), 32'(spread(lin)));
    check("R6 known pattern", 32'(c_txd), 32'h4EB1);
    check("R7 inverse push data", 32'(c_pushd), 32'(gather(16'hB14E)));
    check("R7 inverse push count", 32'(c_pushn), 32'd2);
    @(negedge clk); cs_active = 1'b0;
    @(negedge clk);
    check("R1 cs drop -> opcode", 32'(phase), 32'd0);
    cs_active = 1'b1;
  endtask

  task automatic t_skip_len(input logic [7:0] op, input int n);
    frame_restart();
    put(op);
    for (int i = 0; i < n; i++) put(8'(i + 1));
    xfer(16'h0);
    check($sformatf("R2 opcode %h loads skip", op), 32'(phase), 32'd1);
    for (int i = 0; i < n - 1; i++) xfer(16'h0);
    check($sformatf("R4 opcode %h not yet striped", op), 32'(phase), 32'd1);
    xfer(16'h0);
    check($sformatf("R4 opcode %h striped after %0d", op, n), 32'(phase), 32'd3);
    drain();
  endtask

  task automatic t_other();
    frame_restart();
    put(8'h9F);
    for (int i = 0; i < 7; i++) put(8'hC0 + 8'(i));
    xfer(16'h0);
    check("R3 unknown -> passthrough", 32'(phase), 32'd2);
    for (int i = 0; i < 7; i++) begin
      xfer(16'h0);
      check("R3 passthrough pop 1", 32'(c_popn), 32'd1);
      check("R3 passthrough dup", 32'(c_txd), 32'({2{8'hC0 + 8'(i)}}));
    end
    check("R3 stays passthrough", 32'(phase), 32'd2);
  endtask

  task automatic t_overflow();
    put(8'h55);
    rx_full = 1'b1;
    xfer(16'hAAAA);
    rx_full = 1'b0;
    check("R8 no push when full", 32'(c_push), 32'd0);
    check("R8 overflow pulse", 32'(c_ovf), 32'd1);
    @(negedge clk);
    check("R8 overflow one cycle", 32'(overflow_evt), 32'd0);
  endtask

  task automatic t_underflow();
    drain();
    xfer(16'h0);
    check("R9 empty no pop", 32'(c_pop), 32'd0);
    check("R9 underflow pulse", 32'(c_under), 32'd1);
    linear_mode = 1'b1;
    xfer(16'h0);
    check("R9 linear mode quiet", 32'(c_under), 32'd0);
    linear_mode = 1'b0;
    frame_restart();
    put(8'h02); put(8'h1); put(8'h2); put(8'h3); put(8'h77);
    for (int i = 0; i < 4; i++) xfer(16'h0);
    check("R4 page program striped", 32'(phase), 32'd3);
    xfer(16'h0);
    check("R9 one byte in striped no pop", 32'(c_pop), 32'd0);
    check("R9 one byte in striped underflow", 32'(c_under), 32'd1);
    check("R9 phase unchanged", 32'(phase), 32'd3);
    drain();
  endtask

  initial begin
    refresh();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    cs_active = 1'b1;
    t_read_cmd();
    t_skip_len(8'hEB, 6);
    t_skip_len(8'h0B, 4);
    t_skip_len(8'hA2, 3);
    t_other();
    t_overflow();
    t_underflow();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule